// File: doc/BRIEF.md
# Serial-Loaded Digital Potentiometer Controller

This block is the digital core of a 128-step variable resistor. A host writes a new wiper position over a three-wire serial port: a serial clock, an active-low select and a data line. While the select is low, each rising serial clock edge pushes one data bit into a seven-bit shift register. When the select returns high, the register contents are copied into a wiper latch. The latch drives the resistor ladder through a one-hot tap select. Bit 0 of that vector is the contact at the B end, and each higher code steps one tap toward A.

The far end of the shift register is brought out as a serial output, so several devices can share one data line in a chain. A disabled output reads as logic high, as an open-drain pin with a pull-up would. An active-low preset pin centres the wiper. An active-low sleep pin opens terminal A, shorts the wiper to B and switches the serial output off. Through sleep the latch keeps its value and the serial port still accepts data.

All pins are asynchronous to the system clock. They pass through two-stage synchronisers. The serial clock and select rising edges then become single-cycle pulses in the system domain.

Top module: `dpot_ctrl`

## Requirements
- R1: While the synchronised select is low, each rising serial clock edge shifts the sdi bit into bit 0 of the seven-bit shift register, and the older bits move up one place.
- R2: A rising edge on the select copies the shift register into wiper_code. The bit shifted in first of the last seven is the MSB, and any earlier bits are discarded.
- R3: When sleep is inactive, sdo equals the bit that was shifted in seven serial clocks earlier. Two chained devices therefore take 14 clocks under one select-low period.
- R4: While preset_n is low, wiper_code is 0x40 and the shift register is cleared, so sdo reads 0 when sleep is inactive. Serial clocks and the select have no effect during this time.
- R5: If preset_n is released while the select is high, wiper_code stays at 0x40.
- R6: While sleep_n is low, a_open and w_to_b are 1, sdo_en is 0, sdo is 1 and tap_sel is all zeros.
- R7: During sleep, wiper_code keeps its value and serial loads still update it. When sleep ends, tap_sel selects the code the latch holds at that time.
- R8: While the select is high, serial clock and sdi activity leave wiper_code and sdo unchanged.
- R9: Outside sleep, tap_sel is one-hot with bit wiper_code set. Code 0x00 sets bit 0 (the B end) and code 0x7F sets bit 127.
- R10: A pin change takes effect on the outputs within four system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| sclk | input | 1 | Serial clock, rising edge shifts |
| cs_n | input | 1 | Active-low serial select; rising edge loads the latch |
| sdi | input | 1 | Serial data in |
| preset_n | input | 1 | Active-low midscale preset |
| sleep_n | input | 1 | Active-low shutdown |
| wiper_code | output | 7 | Wiper latch contents |
| tap_sel | output | 128 | One-hot ladder tap select, zero in sleep |
| a_open | output | 1 | Terminal A disconnect request |
| w_to_b | output | 1 | Wiper-to-B short request |
| sdo_en | output | 1 | Serial output driver enable |
| sdo | output | 1 | Serial data out, 1 when disabled |

## Verification
A corrupted shift register appears at sdo seven serial clocks later than it occurred. It reaches wiper_code on the next select rising edge. A latch that loads when it should hold, or that misses the preset, shows up on wiper_code and tap_sel within one system cycle after the synchroniser delay. A fault in the sleep gating shows up at once on tap_sel, sdo and the two terminal flags. Each check therefore waits a fixed four cycles after a pin change before it samples.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic sdi;
    logic preset_n;
    logic sleep_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, sdi: 1'b0,
                                  preset_n: 1'b1, sleep_n: 1'b1};

  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_SHIFT = 2'd1,
    SR_CLEAR = 2'd2
  } sr_op_e;

  typedef enum logic [1:0] {
    LT_HOLD = 2'd0,
    LT_LOAD = 2'd1,
    LT_MID  = 2'd2
  } lt_op_e;

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dpot_edge.sv
module dpot_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/dpot_shift.sv
module dpot_shift
  import dpot_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sr_op_e            op,
  input  logic              din,
  output logic [CODE_W-1:0] q,
  output logic              tail
);
  function automatic logic [CODE_W-1:0] shift_in(input logic [CODE_W-1:0] cur,
                                                 input logic bit_in);
    return {cur[CODE_W-2:0], bit_in};
  endfunction

  logic [CODE_W-1:0] sr_d;

  always_comb begin
    unique case (op)
      SR_SHIFT: sr_d = shift_in(q, din);
      SR_CLEAR: sr_d = '0;
      default:  sr_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sr_d;
  end

  assign tail = q[CODE_W-1];
endmodule

// File: rtl/dpot_latch.sv
module dpot_latch
  import dpot_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lt_op_e            op,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] q
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] lt_d;

  always_comb begin
    unique case (op)
      LT_LOAD: lt_d = din;
      LT_MID:  lt_d = MID;
      default: lt_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= MID;
    else        q <= lt_d;
  end
endmodule

// File: rtl/dpot_tapdec.sv
module dpot_tapdec #(
  parameter int CODE_W = 7,
  localparam int TAPS  = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              blank,
  output logic [TAPS-1:0]   tap
);
  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap[t] = ~blank & (code == CODE_W'(t));
    end
  endgenerate
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int TAPS       = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              preset_n,
  input  logic              sleep_n,
  output logic [CODE_W-1:0] wiper_code,
  output logic [TAPS-1:0]   tap_sel,
  output logic              a_open,
  output logic              w_to_b,
  output logic              sdo_en,
  output logic              sdo
);
  pins_t pins_raw, pins_s;

  // Named internal events, used by the bound checker.
  logic              sclk_rise, cs_rise;
  logic              shift_en, load_en;
  logic              preset_act, shdn_act;
  logic              sdi_s;
  logic [CODE_W-1:0] sr_q;
  logic              sr_tail;
  sr_op_e            sr_op;
  lt_op_e            lt_op;

  assign pins_raw = '{sclk: sclk, cs_n: cs_n, sdi: sdi,
                      preset_n: preset_n, sleep_n: sleep_n};

  dpot_sync #(
    .W       ($bits(pins_t)),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  dpot_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk (clk), .rst_n (sys_rst_n), .lvl (pins_s.sclk), .rise (sclk_rise)
  );

  dpot_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk (clk), .rst_n (sys_rst_n), .lvl (pins_s.cs_n), .rise (cs_rise)
  );

  assign sdi_s      = pins_s.sdi;
  assign preset_act = ~pins_s.preset_n;
  assign shdn_act   = ~pins_s.sleep_n;
  assign shift_en   = sclk_rise & ~pins_s.cs_n;
  assign load_en    = cs_rise;

  always_comb begin
    if (preset_act)    sr_op = SR_CLEAR;
    else if (shift_en) sr_op = SR_SHIFT;
    else               sr_op = SR_HOLD;
  end

  always_comb begin
    if (preset_act)   lt_op = LT_MID;
    else if (load_en) lt_op = LT_LOAD;
    else              lt_op = LT_HOLD;
  end

  dpot_shift #(.CODE_W(CODE_W)) u_shift (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .op    (sr_op),
    .din   (sdi_s),
    .q     (sr_q),
    .tail  (sr_tail)
  );

  dpot_latch #(.CODE_W(CODE_W)) u_latch (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .op    (lt_op),
    .din   (sr_q),
    .q     (wiper_code)
  );

  dpot_tapdec #(.CODE_W(CODE_W)) u_tapdec (
    .code  (wiper_code),
    .blank (shdn_act),
    .tap   (tap_sel)
  );

  assign a_open = shdn_act;
  assign w_to_b = shdn_act;
  assign sdo_en = ~shdn_act;
  assign sdo    = sdo_en ? sr_tail : 1'b1;
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
  parameter int CODE_W = 7,
  localparam int TAPS  = 1 << CODE_W
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              sdi_s,
  input logic              shift_en,
  input logic              load_en,
  input logic              preset_act,
  input logic              shdn_act,
  input logic [CODE_W-1:0] sr_q,
  input logic [CODE_W-1:0] wiper_code,
  input logic [TAPS-1:0]   tap_sel,
  input logic              a_open,
  input logic              w_to_b,
  input logic              sdo
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (shift_en && !preset_act) |=> (sr_q[0] == $past(sdi_s)));

  p_load_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (load_en && !preset_act) |=> (wiper_code == $past(sr_q)));

  p_sdo_tail_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !shdn_act |-> (sdo == sr_q[CODE_W-1]));

  p_preset_mid_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    preset_act |=> (wiper_code == MID && sr_q == '0));

  p_sleep_flags_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    shdn_act |-> (a_open && w_to_b && sdo && tap_sel == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!load_en && !preset_act) |=> $stable(wiper_code));

  p_onehot_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !shdn_act |-> ($countones(tap_sel) == 1 && tap_sel[wiper_code]));
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .sys_rst_n  (sys_rst_n),
  .sdi_s      (sdi_s),
  .shift_en   (shift_en),
  .load_en    (load_en),
  .preset_act (preset_act),
  .shdn_act   (shdn_act),
  .sr_q       (sr_q),
  .wiper_code (wiper_code),
  .tap_sel    (tap_sel),
  .a_open     (a_open),
  .w_to_b     (w_to_b),
  .sdo        (sdo)
);

// File: tb/tb_dpot_ctrl.sv
module tb_dpot_ctrl;
  logic         clk = 1'b0;
  logic         sys_rst_n = 1'b0;
  logic         sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic         preset_n = 1'b1, sleep_n = 1'b1;
  logic [6:0]   wiper_code;
  logic [127:0] tap_sel;
  logic         a_open, w_to_b, sdo_en, sdo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  dpot_ctrl dut (
    .clk (clk), .sys_rst_n (sys_rst_n), .sclk (sclk), .cs_n (cs_n), .sdi (sdi),
    .preset_n (preset_n), .sleep_n (sleep_n), .wiper_code (wiper_code),
    .tap_sel (tap_sel), .a_open (a_open), .w_to_b (w_to_b),
    .sdo_en (sdo_en), .sdo (sdo)
  );

  function automatic logic [127:0] onehot(input int idx);
    logic [127:0] v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // R10: every pin change is followed by four system cycles before sampling.
  task automatic pin_bit(input logic b);
    sdi = b;  step(4);
    sclk = 1; step(4);
    sclk = 0; step(4);
  endtask

  task automatic send(input logic [31:0] data, input int nbits);
    cs_n = 0; step(4);
    for (int i = nbits - 1; i >= 0; i--) pin_bit(data[i]);
    cs_n = 1; step(4);
  endtask

  task automatic t_reset();
    check("R4", "reset wiper", 128'(wiper_code), 128'h40);
    check("R9", "reset tap", tap_sel, onehot(64));
    check("R6", "reset a_open", 128'(a_open), 128'd0);
    check("R4", "reset sdo", 128'(sdo), 128'd0);
  endtask

  task automatic t_load();
    send(32'h5A, 7);
    check("R2", "load 5A", 128'(wiper_code), 128'h5A);
    check("R9", "tap 5A", tap_sel, onehot(8'h5A));
    send(32'h00, 7);
    check("R9", "tap code 0 is B end", tap_sel, onehot(0));
    send(32'h7F, 7);
    check("R9", "tap code 7F", tap_sel, onehot(127));
  endtask

  task automatic t_extra_bits();
    send(32'h2B3, 10);
    check("R2", "last seven of ten", 128'(wiper_code), 128'h33);
  endtask

  task automatic t_sdo_delay();
    logic [13:0] pat = 14'b10110011100101;
    int errs = 0;
    cs_n = 0; step(4);
    for (int i = 0; i < 14; i++) begin
      pin_bit(pat[13 - i]);
      if (i >= 6 && sdo !== pat[13 - (i - 6)]) errs++;
    end
    cs_n = 1; step(4);
    check("R3", "sdo seven-bit delay mismatches", 128'(errs), 128'd0);
    check("R1", "shift pattern into latch", 128'(wiper_code), 128'(pat[6:0]));
    check("R3", "sdo after 14 bits", 128'(sdo), 128'(pat[6]));
  endtask

  task automatic t_cs_high_ignored();
    logic [6:0] before_code = wiper_code;
    logic       before_sdo  = sdo;
    for (int i = 0; i < 5; i++) pin_bit(i[0]);
    check("R8", "wiper with cs high", 128'(wiper_code), 128'(before_code));
    check("R8", "sdo with cs high", 128'(sdo), 128'(before_sdo));
  endtask

  task automatic t_preset();
    send(32'h7F, 7);
    check("R3", "sdo high before preset", 128'(sdo), 128'd1);
    preset_n = 0; step(4);
    check("R4", "preset wiper", 128'(wiper_code), 128'h40);
    check("R4", "preset clears sdo", 128'(sdo), 128'd0);
    cs_n = 0; step(4);
    pin_bit(1'b1);
    cs_n = 1; step(4);
    check("R4", "cs edge ignored in preset", 128'(wiper_code), 128'h40);
    preset_n = 1; step(4);
    check("R5", "release with cs high", 128'(wiper_code), 128'h40);
  endtask

  task automatic t_sleep();
    send(32'h23, 7);
    sleep_n = 0; step(4);
    check("R6", "a_open", 128'(a_open), 128'd1);
    check("R6", "w_to_b", 128'(w_to_b), 128'd1);
    check("R6", "sdo off", 128'({sdo_en, sdo}), 128'b01);
    check("R6", "tap blank", tap_sel, 128'd0);
    check("R7", "latch kept", 128'(wiper_code), 128'h23);
    send(32'h61, 7);
    check("R7", "load during sleep", 128'(wiper_code), 128'h61);
    check("R6", "tap still blank", tap_sel, 128'd0);
    sleep_n = 1; step(4);
    check("R7", "wake tap", tap_sel, onehot(8'h61));
    check("R6", "a_open cleared", 128'({a_open, w_to_b, sdo_en}), 128'b001);
  endtask

  initial begin
    step(3);
    sys_rst_n = 1;
    step(4);
    t_reset();
    t_load();
    t_extra_bits();
    t_sdo_delay();
    t_cs_high_ignored();
    t_preset();
    t_sleep();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule